// File: doc/BRIEF.md
# Encoder Input Glitch Filter

This block cleans up the raw signals coming from an incremental position encoder before they reach a quadrature decoder. It handles four lines: the two quadrature phases, the index (zero) marker and an auxiliary marker. Each line is brought into the system clock domain by a two-flop synchronizer. It then passes through a per-channel filter state machine that commits a new level only after that level has been seen on three consecutive filter samples. Shorter disturbances, such as single-clock spikes, never reach the output.

Filter samples are taken on a sample strobe. A shared down counter produces this strobe once every `N+1` system clocks, where `N` is a 6-bit divider setting applied at an input port. With `N = 0` the filters sample on every clock, which gives the lightest filtering. A larger `N` rejects longer disturbances, but it also lowers the highest encoder edge rate that passes through reliably, which is about `fclk / (6 × (N+1))`.

Each channel filter has three states. `FS_STABLE` means the sample agrees with the committed output. `FS_SEEN1` means one disagreeing sample has been seen. `FS_SEEN2` means two consecutive disagreeing samples have been seen. On a strobe, a disagreeing sample moves `FS_STABLE` to `FS_SEEN1` and `FS_SEEN1` to `FS_SEEN2`. In `FS_SEEN2`, a third disagreeing sample flips the output and returns the filter to `FS_STABLE`. In `FS_SEEN1` or `FS_SEEN2`, an agreeing sample falls back to `FS_STABLE`. Without a strobe, the state holds.

Top module: `enc_input_filter`

## Requirements
- R1: After reset all four clean outputs are 0, the synchronizers and filter states are cleared, and the outputs stay 0 while the raw inputs stay 0.
- R2: With the divider setting at 0 the sample strobe is active on every clock, and a held step on a raw input appears on the matching output exactly 5 clock edges after it is applied (2 synchronizer edges plus 3 samples).
- R3: A sample that agrees with the committed output never changes it. With the setting at 0, a raw pulse of 1 or 2 clocks never appears at the output.
- R4: With the setting at 0, a raw pulse that lasts 3 or more clocks appears at the output, and each committed change equals the synchronized sample taken on that strobe.
- R5: With setting N above 0, the strobe is never active on two consecutive clocks, and a held step reaches the output between 5+2N and 5+3N clock edges after it is applied.
- R6: With setting N, a raw pulse of 2(N+1) clocks is rejected and a raw pulse of 3(N+1) clocks is accepted.
- R7: Channels are independent and identical. Bit 0 is phase A, bit 1 is phase B, bit 2 is the index marker and bit 3 is the auxiliary marker. Raw bit i affects only clean bit i.
- R8: Falling transitions are filtered the same way as rising ones. A 2-clock low pulse on a high input is rejected at setting 0, and a held fall takes 5 edges.
- R9: A clean output changes only on a clock edge where the sample strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| filt_div_i | input | 6 | Divider setting N; strobe period is N+1 clocks |
| enc_raw_i | input | 4 | Raw encoder lines: [0] A, [1] B, [2] index, [3] auxiliary |
| enc_clean_o | output | 4 | Filtered, synchronized lines, same bit order |

## Verification
The bench targets the pulse widths just below and at the acceptance threshold: 2 against 3 clocks at full rate, and 2(N+1) against 3(N+1) clocks at a divided rate. A filter that counts only two samples would pass the short pulses, and one that needs four would swallow the long ones. It measures step latency in both directions at several settings. A strobe counter that is off by one, or a synchronizer that is missing or doubled, moves the latency out of the exact or bounded window. Mixed-channel patterns catch crossed or shared channel state, and a low glitch on high lines catches a filter that only handles rising edges.

// File: rtl/enc_filt_pkg.sv
package enc_filt_pkg;

    // Three-sample confirmation filter states
    typedef enum logic [1:0] {
        FS_STABLE = 2'd0,   // sample agrees with committed output
        FS_SEEN1  = 2'd1,   // one disagreeing sample observed
        FS_SEEN2  = 2'd2    // two consecutive disagreeing samples observed
    } filt_state_e;

    localparam int unsigned DEF_NUM_CH = 4;
    localparam int unsigned DEF_DIV_W  = 6;

endpackage

// File: rtl/filt_tick_gen.sv
module filt_tick_gen #(
    parameter int unsigned DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q == '0);

    // Down counter: reloads with the divider setting on each strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= div_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R2: at setting 0 the strobe keeps firing every clock
    p_full_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i == '0) |=> tick_o);

    // R5: with a nonzero setting a strobe is followed by a quiet clock
    p_divided_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> !tick_o);

endmodule

// File: rtl/sync2.sv
module sync2 #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/chan_filter.sv
module chan_filter
    import enc_filt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic samp_i,
    output logic clean_o
);

    filt_state_e state_q;
    filt_state_e state_d;
    logic        clean_q;
    logic        flip;
    logic        differs;

    assign differs = (samp_i != clean_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        flip    = 1'b0;
        if (tick_i) begin
            unique case (state_q)
                FS_STABLE: state_d = differs ? FS_SEEN1 : FS_STABLE;
                FS_SEEN1:  state_d = differs ? FS_SEEN2 : FS_STABLE;
                FS_SEEN2: begin
                    state_d = FS_STABLE;
                    flip    = differs;
                end
                default:   state_d = FS_STABLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_STABLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean_q <= 1'b0;
        end else if (flip) begin
            clean_q <= ~clean_q;
        end
    end

    assign clean_o = clean_q;

    // R9: the committed level moves only on a strobe edge
    p_move_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(clean_o));

    // R3: an agreeing sample never changes the output
    p_agree_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && samp_i == clean_o) |=> $stable(clean_o));

    // R4: a committed change takes the value that was sampled
    p_flip_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean_o) |-> (clean_o == $past(samp_i)));

endmodule

// File: rtl/enc_input_filter.sv
module enc_input_filter
    import enc_filt_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned DIV_W  = DEF_DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  filt_div_i,
    input  logic [NUM_CH-1:0] enc_raw_i,
    output logic [NUM_CH-1:0] enc_clean_o
);

    logic              samp_tick;
    logic [NUM_CH-1:0] synced;

    filt_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (filt_div_i),
        .tick_o (samp_tick)
    );

    sync2 #(.WIDTH(NUM_CH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (enc_raw_i),
        .q_o   (synced)
    );

    // R7: one independent filter per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        chan_filter u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (samp_tick),
            .samp_i  (synced[ch]),
            .clean_o (enc_clean_o[ch])
        );
    end

endmodule

// File: tb/enc_input_filter_tb.sv
`timescale 1ns/1ps
module enc_input_filter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] filt_div_i = '0;
    logic [3:0] enc_raw_i = '0;
    logic [3:0] enc_clean_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    enc_input_filter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .filt_div_i  (filt_div_i),
        .enc_raw_i   (enc_raw_i),
        .enc_clean_o (enc_clean_o)
    );

    // Vector: {pattern[3:0], width[3:0], accepted}, setting 0
    localparam logic [8:0] VEC [8] = '{
        {4'b0001, 4'd1, 1'b0},
        {4'b0010, 4'd2, 1'b0},
        {4'b0100, 4'd3, 1'b1},
        {4'b1000, 4'd4, 1'b1},
        {4'b0011, 4'd2, 1'b0},
        {4'b1111, 4'd3, 1'b1},
        {4'b0101, 4'd1, 1'b0},
        {4'b1010, 4'd5, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // Drive a pulse of given width from base level; return OR and AND of outputs seen
    task automatic pulse(input logic [3:0] base, input logic [3:0] pat, input int width,
                         input int tail, output logic [3:0] seen_or, output logic [3:0] seen_and);
        enc_raw_i = pat;
        seen_or   = '0;
        seen_and  = '1;
        for (int i = 0; i < width + tail; i++) begin
            @(negedge clk);
            if (i == width - 1) enc_raw_i = base;
            seen_or  = seen_or | enc_clean_o;
            seen_and = seen_and & enc_clean_o;
        end
    endtask

    // Apply a held level and count edges until the output matches
    task automatic latency(input logic [3:0] target, output int edges);
        enc_raw_i = target;
        edges = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (enc_clean_o == target) break;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] s_or, s_and;
        int lat;

        repeat (3) @(negedge clk);
        check("R1 reset outputs", {28'd0, enc_clean_o}, 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 quiet after reset", {28'd0, enc_clean_o}, 32'd0);

        // Table walk at setting 0: R3 short pulses rejected, R4 long accepted, R7 per-channel
        foreach (VEC[k]) begin
            pulse(4'b0000, VEC[k][8:5], int'(VEC[k][4:1]), 12, s_or, s_and);
            check(VEC[k][0] ? "R4 pulse accepted" : "R3 pulse rejected",
                  {28'd0, s_or}, VEC[k][0] ? {28'd0, VEC[k][8:5]} : 32'd0);
            check("R7 channels return low", {28'd0, enc_clean_o}, 32'd0);
        end

        // R2: exact latency at full rate, rising
        latency(4'b0110, lat);
        check("R2 rise latency", lat, 5);
        // R8: exact latency falling
        latency(4'b0000, lat);
        check("R8 fall latency", lat, 5);

        // R8: low glitch on high lines rejected
        latency(4'b1111, lat);
        pulse(4'b1111, 4'b0000, 2, 12, s_or, s_and);
        check("R8 low glitch rejected", {28'd0, s_and}, 32'd15);
        pulse(4'b1111, 4'b1011, 3, 12, s_or, s_and);
        check("R8 R7 3-clock low on bit2 only", {28'd0, s_and}, 32'd11);
        latency(4'b0000, lat);
        check("R8 settle low", {28'd0, enc_clean_o}, 32'd0);

        // R5 / R6 at setting 2
        filt_div_i = 6'd2;
        repeat (20) @(negedge clk);
        latency(4'b0001, lat);
        check_range("R5 rise latency N=2", lat, 9, 11);
        latency(4'b0000, lat);
        check_range("R5 fall latency N=2", lat, 9, 11);
        repeat (5) @(negedge clk);
        pulse(4'b0000, 4'b1000, 6, 20, s_or, s_and);
        check("R6 2(N+1) pulse rejected N=2", {28'd0, s_or}, 32'd0);
        pulse(4'b0000, 4'b0100, 9, 20, s_or, s_and);
        check("R6 3(N+1) pulse accepted N=2", {28'd0, s_or}, 32'd4);
        check("R6 output back low N=2", {28'd0, enc_clean_o}, 32'd0);

        // R5 / R6 at setting 5
        filt_div_i = 6'd5;
        repeat (30) @(negedge clk);
        latency(4'b0010, lat);
        check_range("R5 rise latency N=5", lat, 15, 20);
        latency(4'b0000, lat);
        check_range("R5 fall latency N=5", lat, 15, 20);
        pulse(4'b0000, 4'b0001, 12, 30, s_or, s_and);
        check("R6 2(N+1) pulse rejected N=5", {28'd0, s_or}, 32'd0);
        pulse(4'b0000, 4'b0001, 18, 30, s_or, s_and);
        check("R6 3(N+1) pulse accepted N=5", {28'd0, s_or}, 32'd1);

        // R1: reset mid-activity clears outputs
        filt_div_i = 6'd0;
        latency(4'b1111, lat);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears outputs", {28'd0, enc_clean_o}, 32'd0);
        enc_raw_i = '0;
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 stays low after reset", {28'd0, enc_clean_o}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule